// File: doc/BRIEF.md
# External Data Space Router

This block sits between a CPU's external-data load/store path and two possible targets: a 1 KB on-chip data RAM and an off-chip multiplexed memory bus. Every access that the CPU issues on the external-data path arrives here as a 16-bit address, a read or write strobe and a write byte. The block decides where the access goes, carries it out, and returns the read byte with a one-cycle ready pulse.

A single enable input decides whether the on-chip RAM is mapped at all. It is captured into a register that reset clears. While the captured bit is low, the whole 64 KB data space is passed to the external bus. While it is high, the lowest 1 KB window is served by the local RAM, and everything from the window limit upward still goes off-chip. The local RAM answers in one cycle. An off-chip access holds a request toward an external bus interface, keeping the address, direction and data stable until that interface acknowledges. The RAM serves data accesses only and has no path to instruction fetch.

The block has one access in flight at a time. The CPU must wait for ready before it issues the next strobe. It may issue that strobe in the same cycle that ready is high.

Top module: `xdata_router`

## Requirements
- R1: After reset, `cpu_ready` and `ext_req` are low and the overlay is off. Every access, including addresses 0000h-03FFh, goes to the external bus until `lram_en` has been captured high.
- R2: `lram_en` is sampled on every clock edge into a register that reset clears. A strobe is decoded with the value captured at the previous edge, so raising `lram_en` in the same cycle as a strobe does not affect that strobe.
- R3: With the overlay on, an access to an address below 0400h (upper six address bits zero) is served by the on-chip RAM and never raises `ext_req`.
- R4: An on-chip access raises `cpu_ready` for exactly one cycle, in the cycle after the strobe. For a read, `cpu_rdata` holds the stored byte in that cycle.
- R5: An on-chip write stores `cpu_wdata` at the decoded offset, and a later on-chip read of the same address returns it.
- R6: An access to an address from 0400h to FFFFh goes to the external bus even while the overlay is on.
- R7: An external access raises `ext_req` in the cycle after the strobe. During the request, `ext_addr`, `ext_we` (1 = write, 0 = read) and `ext_wdata` stay stable until `ext_ack` is sampled high. At the next cycle `ext_req` is low and `cpu_ready` pulses. For a read, `cpu_rdata` then equals the `ext_rdata` sampled together with the acknowledge.
- R8: `cpu_ready` stays low for as long as an external request is waiting for its acknowledge.
- R9: Strobes that arrive while an external access is pending are ignored. They cause no RAM write, no new request and no extra ready pulse.
- R10: A strobe with `cpu_rd` and `cpu_wr` both high is handled as a write.
- R11: Clearing `lram_en` makes the 1 KB window transparent, so its addresses go external. The RAM keeps its contents, and they can be read again once the overlay is re-enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Access address |
| cpu_rd | input | 1 | Read strobe, one cycle |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_wdata | input | 8 | Write byte |
| lram_en | input | 1 | On-chip RAM mapping enable bit |
| cpu_rdata | output | 8 | Read byte, valid while cpu_ready is high after a read |
| cpu_ready | output | 1 | One-cycle completion pulse |
| ext_req | output | 1 | External bus request, held until acknowledged |
| ext_we | output | 1 | External access direction, 1 = write |
| ext_addr | output | 16 | External access address |
| ext_wdata | output | 8 | External write byte |
| ext_ack | input | 1 | External bus acknowledge |
| ext_rdata | input | 8 | External read byte, sampled with ext_ack |

## Verification
The bench builds the block with its defaults: a 16-bit address, 8-bit data and a 10-bit local window. This places the 03FFh/0400h boundary and both ends of the 64 KB space (0000h and FFFFh) within direct reach. Acknowledge delays from zero to five cycles exercise the ready latency and the request-hold window. A strobe injected during a five-cycle wait tests the single-access rule. Toggling the enable in the same cycle as a strobe tests the one-cycle capture of the mapping bit.

// File: rtl/xdr_pkg.sv
// Shared types for the external data space router.
// Assumes: nothing beyond IEEE 1800-2017.
package xdr_pkg;

    // Controller states: idle, or waiting for the external bus acknowledge
    typedef enum logic [0:0] {
        XS_IDLE = 1'b0,
        XS_EXT  = 1'b1
    } xdr_state_e;

    // Default geometry of the data space and the local window
    localparam int XDR_ADDR_W  = 16;
    localparam int XDR_DATA_W  = 8;
    localparam int XDR_LOCAL_AW = 10;

endpackage

// File: rtl/xdr_decode.sv
// Address comparator: flags an access as local when the overlay is on
// and the address lies below 2**LOCAL_AW.
// Assumes: LOCAL_AW <= ADDR_W.
module xdr_decode #(
    parameter int ADDR_W   = 16,
    parameter int LOCAL_AW = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ovl_on,
    output logic              hit_local
);
    localparam logic [ADDR_W:0] WIN_LIMIT = (ADDR_W+1)'(1) << LOCAL_AW;

    logic in_window;

    // Compare against the window limit; the window is only live when the overlay is on
    always_comb begin
        in_window = ({1'b0, addr} < WIN_LIMIT);
        hit_local = ovl_on & in_window;
    end
endmodule

// File: rtl/xdr_ram.sv
// Single-port on-chip data RAM with a synchronous write and a registered read.
// Assumes: the caller raises cs for one cycle per access; rdata updates only on reads.
module xdr_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Storage array: write on a selected write cycle
    always_ff @(posedge clk) begin
        if (cs && we) begin
            mem[addr] <= wdata;
        end
    end

    // Read register: capture the addressed byte on a selected read cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (cs && !we) begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/xdr_ctrl.sv
// Access controller: accepts one strobe at a time and steers it to the
// local RAM or to a held external request, then pulses ready.
// Assumes: strobes are single-cycle; strobes seen while busy are dropped;
// a strobe with both read and write high is a write.
module xdr_ctrl
    import xdr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              hit_local,
    output logic              ram_cs,
    output logic              ram_we,
    output logic              ext_req,
    output logic              ext_we,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic              ext_ack,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              cpu_ready,
    output logic              src_local,
    output logic [DATA_W-1:0] ext_rdata_q,
    output logic              busy
);
    xdr_state_e state_q;
    logic       accept;

    // Accept a strobe only while idle and forward local ones straight to the RAM
    always_comb begin
        accept = (state_q == XS_IDLE) && (cpu_rd || cpu_wr);
        ram_cs = accept && hit_local;
        ram_we = cpu_wr;
        busy   = (state_q == XS_EXT);
    end

    // Sequencer: launch, hold and retire accesses and produce the ready pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= XS_IDLE;
            ext_req     <= 1'b0;
            ext_we      <= 1'b0;
            ext_addr    <= '0;
            ext_wdata   <= '0;
            cpu_ready   <= 1'b0;
            src_local   <= 1'b0;
            ext_rdata_q <= '0;
        end else begin
            cpu_ready <= 1'b0;
            case (state_q)
                XS_IDLE: begin
                    if (accept) begin
                        if (hit_local) begin
                            cpu_ready <= 1'b1;
                            src_local <= 1'b1;
                        end else begin
                            state_q   <= XS_EXT;
                            ext_req   <= 1'b1;
                            ext_we    <= cpu_wr;
                            ext_addr  <= cpu_addr;
                            ext_wdata <= cpu_wdata;
                        end
                    end
                end
                XS_EXT: begin
                    if (ext_ack) begin
                        state_q   <= XS_IDLE;
                        ext_req   <= 1'b0;
                        cpu_ready <= 1'b1;
                        src_local <= 1'b0;
                        if (!ext_we) begin
                            ext_rdata_q <= ext_rdata;
                        end
                    end
                end
                default: state_q <= XS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xdata_router.sv
// External data space router: captures the overlay enable, decodes each
// access, runs the local RAM or the external request, and muxes read data.
// Assumes: LOCAL_AW <= ADDR_W; one access in flight at a time.
module xdata_router #(
    parameter int ADDR_W   = xdr_pkg::XDR_ADDR_W,
    parameter int DATA_W   = xdr_pkg::XDR_DATA_W,
    parameter int LOCAL_AW = xdr_pkg::XDR_LOCAL_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              lram_en,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              ext_req,
    output logic              ext_we,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic              ext_ack,
    input  logic [DATA_W-1:0] ext_rdata
);
    logic              ovl_en_q;
    logic              hit_local;
    logic              ram_cs;
    logic              ram_we;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] ext_rdata_q;
    logic              src_local;
    logic              acc_busy;

    // Mapping enable register, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovl_en_q <= 1'b0;
        end else begin
            ovl_en_q <= lram_en;
        end
    end

    xdr_decode #(
        .ADDR_W  (ADDR_W),
        .LOCAL_AW(LOCAL_AW)
    ) decode_i (
        .addr     (cpu_addr),
        .ovl_on   (ovl_en_q),
        .hit_local(hit_local)
    );

    xdr_ctrl #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .hit_local  (hit_local),
        .ram_cs     (ram_cs),
        .ram_we     (ram_we),
        .ext_req    (ext_req),
        .ext_we     (ext_we),
        .ext_addr   (ext_addr),
        .ext_wdata  (ext_wdata),
        .ext_ack    (ext_ack),
        .ext_rdata  (ext_rdata),
        .cpu_ready  (cpu_ready),
        .src_local  (src_local),
        .ext_rdata_q(ext_rdata_q),
        .busy       (acc_busy)
    );

    xdr_ram #(
        .AW(LOCAL_AW),
        .DW(DATA_W)
    ) ram_i (
        .clk  (clk),
        .rst_n(rst_n),
        .cs   (ram_cs),
        .we   (ram_we),
        .addr (cpu_addr[LOCAL_AW-1:0]),
        .wdata(cpu_wdata),
        .rdata(ram_rdata)
    );

    // Read-data return mux: pick the source of the access that just completed
    always_comb begin
        cpu_rdata = src_local ? ram_rdata : ext_rdata_q;
    end
endmodule

// File: rtl/xdr_checker.sv
// Protocol checker for the external data space router, bound to the top.
// Assumes: the same parameters as the top it is bound to.
module xdr_checker #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int LOCAL_AW = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic              cpu_ready,
    input logic              ext_req,
    input logic              ext_we,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [DATA_W-1:0] ext_wdata,
    input logic              ext_ack,
    input logic              ovl_en_q,
    input logic              acc_busy
);
    localparam logic [ADDR_W:0] WIN_LIMIT = (ADDR_W+1)'(1) << LOCAL_AW;

    logic strobe_idle;
    logic below_lim;
    assign strobe_idle = !acc_busy && (cpu_rd || cpu_wr);
    assign below_lim   = ({1'b0, cpu_addr} < WIN_LIMIT);

    assert_local_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_idle && ovl_en_q && below_lim) |=> (!ext_req && cpu_ready));

    assert_high_goes_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_idle && !below_lim) |=> (ext_req && !cpu_ready));

    assert_transparent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_idle && !ovl_en_q) |=> ext_req);

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr) && $stable(ext_we)
                                    && $stable(ext_wdata)));

    assert_no_ready_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_ack) |=> !cpu_ready);

    assert_ack_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && ext_ack) |=> (cpu_ready && !ext_req));

    assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !cpu_rd && !cpu_wr) |=> !cpu_ready);

    assert_both_is_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_idle && cpu_rd && cpu_wr && !below_lim) |=> ext_we);
endmodule

bind xdata_router xdr_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .LOCAL_AW(LOCAL_AW)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_rd   (cpu_rd),
    .cpu_wr   (cpu_wr),
    .cpu_ready(cpu_ready),
    .ext_req  (ext_req),
    .ext_we   (ext_we),
    .ext_addr (ext_addr),
    .ext_wdata(ext_wdata),
    .ext_ack  (ext_ack),
    .ovl_en_q (ovl_en_q),
    .acc_busy (acc_busy)
);

// File: tb/xdata_router_tb.sv
// Scoreboard bench: the driver queues expected completions, the monitor
// pops and compares them on every ready pulse.
module xdata_router_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic        lram_en = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready;
    logic        ext_req;
    logic        ext_we;
    logic [15:0] ext_addr;
    logic [7:0]  ext_wdata;
    logic        ext_ack = 1'b0;
    logic [7:0]  ext_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xdata_router dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .cpu_rd   (cpu_rd),
        .cpu_wr   (cpu_wr),
        .cpu_wdata(cpu_wdata),
        .lram_en  (lram_en),
        .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready),
        .ext_req  (ext_req),
        .ext_we   (ext_we),
        .ext_addr (ext_addr),
        .ext_wdata(ext_wdata),
        .ext_ack  (ext_ack),
        .ext_rdata(ext_rdata)
    );

    typedef struct {
        bit          is_ext;
        bit          is_wr;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  rdata;
        int          tag;
    } item_t;

    item_t       sb_q[$];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 0;
    bit          en_model = 0;
    logic [7:0]  ram_m [1024];
    int          ack_delay = 0;
    int          wait_cnt = 0;
    int          ext_acks = 0;
    int          acks_seen = 0;
    logic [15:0] rec_addr = '0;
    logic        rec_we = 1'b0;
    logic [7:0]  rec_wdata = '0;

    function automatic logic [7:0] ext_pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input int tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // External bus model: acknowledge after ack_delay cycles, record the request
    always @(negedge clk) begin
        if (ext_ack) begin
            ext_ack = 1'b0;
        end else if (ext_req) begin
            if (wait_cnt >= ack_delay) begin
                ext_ack   = 1'b1;
                ext_rdata = ext_pat(ext_addr);
                rec_addr  = ext_addr;
                rec_we    = ext_we;
                rec_wdata = ext_wdata;
                ext_acks++;
                wait_cnt  = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    // Monitor: pop one expected item per ready pulse and compare
    always @(negedge clk) begin
        if (rst_n && cpu_ready) begin
            if (sb_q.size() == 0) begin
                chk(0, 9, "unexpected ready pulse", 1, 0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                chk((ext_acks != acks_seen) == it.is_ext, it.tag, "external used",
                    int'(ext_acks != acks_seen), int'(it.is_ext));
                if (it.is_ext) begin
                    chk(rec_addr == it.addr, it.tag, "ext_addr", rec_addr, it.addr);
                    chk(rec_we == it.is_wr, it.tag, "ext_we", rec_we, it.is_wr);
                    if (it.is_wr)
                        chk(rec_wdata == it.wdata, it.tag, "ext_wdata", rec_wdata, it.wdata);
                end
                if (!it.is_wr)
                    chk(cpu_rdata == it.rdata, it.tag, "cpu_rdata", cpu_rdata, it.rdata);
                acks_seen = ext_acks;
            end
        end
    end

    // Driver: issue one access, queue its expectation, check ready latency
    task automatic do_acc(input logic [15:0] a, input bit wr, input bit rd,
                          input logic [7:0] wd, input int dly, input bit noise,
                          input int tag);
        item_t it;
        bit    loc;
        int    n;
        loc       = en_model && (a < 16'h0400);
        it.is_ext = !loc;
        it.is_wr  = wr;
        it.addr   = a;
        it.wdata  = wd;
        it.rdata  = loc ? ram_m[a[9:0]] : ext_pat(a);
        it.tag    = tag;
        if (loc && wr) ram_m[a[9:0]] = wd;
        sb_q.push_back(it);
        ack_delay = dly;
        cpu_addr  = a;
        cpu_rd    = rd;
        cpu_wr    = wr;
        cpu_wdata = wd;
        @(negedge clk);
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
        n = 1;
        while (!cpu_ready && n < 60) begin
            if (noise && n == 2) begin
                cpu_addr = 16'h0010; cpu_wr = 1'b1; cpu_wdata = 8'hEE;
            end
            if (noise && n == 3) cpu_wr = 1'b0;
            @(negedge clk);
            n++;
        end
        cpu_wr = 1'b0;
        chk(n == (loc ? 1 : 2 + dly), tag, "ready latency", n, loc ? 1 : 2 + dly);
    endtask

    task automatic set_en(input bit v);
        lram_en  = v;
        @(negedge clk);
        en_model = v;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R0 watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cpu_ready == 1'b0, 1, "ready after reset", cpu_ready, 0);
        chk(ext_req == 1'b0, 1, "ext_req after reset", ext_req, 0);
        // R1: overlay off after reset, low window goes external
        do_acc(16'h0005, 1, 0, 8'h11, 0, 0, 1);
        do_acc(16'h03FF, 0, 1, 8'h00, 1, 0, 1);
        // R3 and R5: local writes at both window ends and in the middle
        set_en(1);
        do_acc(16'h0000, 1, 0, 8'hA1, 0, 0, 5);
        do_acc(16'h03FF, 1, 0, 8'hB2, 0, 0, 5);
        do_acc(16'h0155, 1, 0, 8'hC3, 0, 0, 3);
        do_acc(16'h0010, 1, 0, 8'h3C, 0, 0, 3);
        // R4: local reads return stored bytes in one cycle
        do_acc(16'h0000, 0, 1, 8'h00, 0, 0, 4);
        do_acc(16'h03FF, 0, 1, 8'h00, 0, 0, 4);
        do_acc(16'h0155, 0, 1, 8'h00, 0, 0, 4);
        // R6: above the window goes external while enabled
        do_acc(16'h0400, 0, 1, 8'h00, 2, 0, 6);
        do_acc(16'hFFFF, 1, 0, 8'h9D, 0, 0, 6);
        // R7 and R8: long acknowledge wait keeps ready low
        do_acc(16'h8001, 0, 1, 8'h00, 4, 0, 8);
        do_acc(16'h1234, 1, 0, 8'h42, 3, 0, 7);
        // R10: both strobes act as a write, locally and externally
        do_acc(16'h0200, 1, 1, 8'h77, 0, 0, 10);
        do_acc(16'h0200, 0, 1, 8'h00, 0, 0, 10);
        do_acc(16'h4321, 1, 1, 8'h5E, 1, 0, 10);
        // R9: a write strobe during a pending external read is dropped
        do_acc(16'h2000, 0, 1, 8'h00, 5, 1, 9);
        do_acc(16'h0010, 0, 1, 8'h00, 0, 0, 9);
        // R11: disabling makes the window transparent, contents survive
        set_en(0);
        do_acc(16'h0000, 0, 1, 8'h00, 0, 0, 11);
        do_acc(16'h0155, 1, 0, 8'h99, 0, 0, 11);
        // R2: enable raised with the strobe does not apply to that strobe
        lram_en = 1'b1;
        do_acc(16'h0001, 0, 1, 8'h00, 0, 0, 2);
        en_model = 1;
        do_acc(16'h0000, 0, 1, 8'h00, 0, 0, 11);
        do_acc(16'h0155, 0, 1, 8'h00, 0, 0, 11);
        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, 4, "pending items", sb_q.size(), 0);
        finish_sim();
    end
endmodule